// File: doc/BRIEF.md
# Prescaled Down-Counting Period Timer

This block is a free-running interval timer. A small prescale counter is decremented on every clock. Each time it passes through zero it is reloaded from a programmable divide ratio, and a 16-bit main counter steps down by one. When both counters sit at zero at the same time, the timer raises an interrupt pulse and a matching output pulse, each one clock long. It then refills the main counter from a period register and carries on. The two counters together give a 20-bit count span. The time between pulses is (ratio+1)×(period+1) clocks.

Software reaches the timer over a simple synchronous register bus. The bus exposes three words: the live main count, the period and a control word. The control word carries the divide ratio, a halt bit, a self-clearing reload strobe, the live prescale value and two spare bits that are only stored. The timer comes out of reset already counting. The usual start-up sequence is: halt the timer, set the ratio and the period, strobe a reload, then clear halt.

Top module: `pdt_timer`

## Requirements
- R1: After reset the main count and the period read 0xFFFF, the ratio and the prescale count read 0xF, the halt bit reads 0 (the timer counts at once), and irq_o and tout_o are low.
- R2: While running, the prescale count decreases by one per clock. When it is 0, the next clock reloads it from the ratio and decreases the main count by one.
- R3: When the prescale count and the main count are both 0 while running, irq_o and tout_o are both high for exactly the following clock, and the main count is refilled from the period in that same step.
- R4: With halt cleared, the first pulse appears (ratio+1)×(period+1) clocks after the clock edge that clears halt, and further pulses follow at that same spacing.
- R5: With the halt bit (control bit 4) set to 1, neither counter changes and no pulse appears.
- R6: Writing the control word with the reload bit (bit 5) set to 1 copies the period into the main count and the ratio field of that same write into the prescale count, whether halted or not. The reload bit always reads back as 0.
- R7: Control word layout: bits 3:0 are the ratio, bit 4 is halt, bit 5 is reload, bits 9:6 are the live prescale count (writes to them are ignored), bits 11:10 are plain stored bits, and bits 15:12 read 0.
- R8: A bus write to the main count appears in the count on the next clock and replaces the decrement of that clock.
- R9: Bus map: address 0 is the main count, 1 is the period, 2 is the control word, and 3 reads 0. A write happens at the clock edge while bus_sel and bus_wr are both high. Read data follows bus_addr without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_o | output | 1 | One-clock interrupt pulse on expiry |
| tout_o | output | 1 | One-clock timer output pulse, in step with irq_o |

## Verification
The assertions assume that no clock both refills the counters and expires. They also assume that a write to the count does not land in the same clock as an expiry, since either event would hide the refill the checks expect. The stimulus follows that rule. Every scenario starts from a halted timer, loads the counters through a reload, and only then clears halt. Each scenario halts the timer again right after its last expected pulse, which is always at least four clocks before the next one could come. The single direct count write is made while the count is far from zero.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_NONE   = 2'd3
  } pdt_addr_e;

  localparam int unsigned AUX_W = 2;
endpackage

// File: rtl/pdt_prescale.sv
module pdt_prescale #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic [PW-1:0] ratio,
  output logic [PW-1:0] pre_q,
  output logic          wrap
);
  // one prescale step: wrap to the ratio from zero, otherwise count down
  function automatic logic [PW-1:0] pre_next(input logic [PW-1:0] cur,
                                              input logic [PW-1:0] rl);
    return (cur == '0) ? rl : cur - 1'b1;
  endfunction

  assign wrap = run && (pre_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    pre_q <= '1;
    else if (load) pre_q <= load_val;
    else if (run)  pre_q <= pre_next(pre_q, ratio);
  end

  a_r2_pre_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && pre_q != '0) |=> (pre_q == $past(pre_q) - 1'b1));

  a_r5_pre_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(pre_q));
endmodule

// File: rtl/pdt_count.sv
module pdt_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic          load,
  input  logic          wr,
  input  logic [CW-1:0] wr_val,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt_q,
  output logic          expire
);
  assign expire = wrap && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '1;
    else if (wr)     cnt_q <= wr_val;
    else if (load)   cnt_q <= period;
    else if (expire) cnt_q <= period;
    else if (wrap)   cnt_q <= cnt_q - 1'b1;
  end

  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !expire && !wr && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r3_refill_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr && !load) |=> (cnt_q == $past(period)));

  a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == $past(wr_val)));
endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
  import pdt_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] cnt_q,
  input  logic [PW-1:0] pre_q,
  output logic [CW-1:0] rdata,
  output logic [CW-1:0] period_q,
  output logic [PW-1:0] ratio_q,
  output logic          halt_q,
  output logic          reload_stb,
  output logic [PW-1:0] reload_ratio,
  output logic          cnt_wr
);
  localparam int unsigned HALT_BIT = PW;
  localparam int unsigned RLD_BIT  = PW + 1;
  localparam int unsigned PRE_LSB  = PW + 2;
  localparam int unsigned AUX_LSB  = 2 * PW + 2;

  logic [AUX_W-1:0] aux_q;
  logic             wr_ctrl;
  logic             wr_per;

  assign wr_ctrl      = sel && wr && (addr == ADDR_CTRL);
  assign wr_per       = sel && wr && (addr == ADDR_PERIOD);
  assign cnt_wr       = sel && wr && (addr == ADDR_COUNT);
  assign reload_stb   = wr_ctrl && wdata[RLD_BIT];
  assign reload_ratio = wdata[PW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '1;
      ratio_q  <= '1;
      halt_q   <= 1'b0;
      aux_q    <= '0;
    end else begin
      if (wr_per) period_q <= wdata;
      if (wr_ctrl) begin
        ratio_q <= wdata[PW-1:0];
        halt_q  <= wdata[HALT_BIT];
        aux_q   <= wdata[AUX_LSB +: AUX_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_COUNT:  rdata = cnt_q;
      ADDR_PERIOD: rdata = period_q;
      ADDR_CTRL: begin
        rdata[PW-1:0]            = ratio_q;
        rdata[HALT_BIT]          = halt_q;
        rdata[PRE_LSB +: PW]     = pre_q;
        rdata[AUX_LSB +: AUX_W]  = aux_q;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             tout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] ratio_q;
  logic [PRE_W-1:0] reload_ratio;
  logic             halt_q;
  logic             reload_stb;
  logic             cnt_wr;
  logic             run;
  logic             wrap;
  logic             expire;

  assign run = !halt_q;

  pdt_regs #(.CW(CNT_W), .PW(PRE_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (bus_sel),
    .wr           (bus_wr),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .cnt_q        (cnt_q),
    .pre_q        (pre_q),
    .rdata        (bus_rdata),
    .period_q     (period_q),
    .ratio_q      (ratio_q),
    .halt_q       (halt_q),
    .reload_stb   (reload_stb),
    .reload_ratio (reload_ratio),
    .cnt_wr       (cnt_wr)
  );

  pdt_prescale #(.PW(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .load     (reload_stb),
    .load_val (reload_ratio),
    .ratio    (ratio_q),
    .pre_q    (pre_q),
    .wrap     (wrap)
  );

  pdt_count #(.CW(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap   (wrap),
    .load   (reload_stb),
    .wr     (cnt_wr),
    .wr_val (bus_wdata),
    .period (period_q),
    .cnt_q  (cnt_q),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      tout_o <= 1'b0;
    end else begin
      irq_o  <= expire;
      tout_o <= expire;
    end
  end

  a_r3_pulse_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(pre_q) == '0 && $past(cnt_q) == '0));

  a_r5_no_pulse_halted: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt_q) |-> (!irq_o && !tout_o));
endmodule

// File: tb/tb_pdt_timer.sv
module tb_pdt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic        tout;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int exp_q[$];
  bit done = 1'b0;

  pdt_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .tout_o(tout)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d, output int edge_i);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    edge_i = cyc + 1;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    addr = a; sel = 1'b1; wr = 1'b0;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  // monitor: each pulse is matched against the next expected edge index
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected pulse actual=%0d expected=none", cyc);
      end else begin
        check("R4 pulse edge", cyc, exp_q.pop_front());
      end
      check("R3 tout with irq", {31'd0, tout}, 32'd1);
    end else if (rst_n && tout) begin
      check("R3 tout without irq", {31'd0, tout}, 32'd0);
    end
  end

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // driver for one interval scenario; pushes the expected pulse edges
  task automatic run_interval(input int r, input int p);
    int e;
    int n;
    logic [15:0] v;
    n = (r + 1) * (p + 1);
    wr_reg(2'd2, 16'h0010 | 16'(r), e);
    wr_reg(2'd1, 16'(p), e);
    wr_reg(2'd2, 16'h0030 | 16'(r), e);
    rd_reg(2'd0, v);
    check("R6 reload copies period", v, 32'(p));
    rd_reg(2'd2, v);
    check("R6 reload reads 0, ratio in prescale", v, 32'(16'h0010 | 16'(r) | 16'(r << 6)));
    wr_reg(2'd2, 16'(r), e);
    exp_q.push_back(e + n);
    exp_q.push_back(e + 2 * n);
    exp_q.push_back(e + 3 * n);
    wait (exp_q.size() == 0);
    wr_reg(2'd2, 16'h0010 | 16'(r), e);
  endtask

  initial begin
    fork
      begin
        repeat (60000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=hung expected=finished");
          summary();
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [15:0] v;
    logic [15:0] v2;
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_reg(2'd0, v);  check("R1 count reset", v, 32'hFFFF);
    rd_reg(2'd1, v);  check("R1 period reset", v, 32'hFFFF);
    rd_reg(2'd2, v);  check("R1 R7 control reset", v, 32'h03CF);
    check("R1 irq low", {31'd0, irq}, 32'd0);
    repeat (3) @(negedge clk);
    rd_reg(2'd2, v);  check("R2 prescale counts down", v, 32'h030F);
    repeat (13) @(negedge clk);
    rd_reg(2'd2, v);  check("R2 prescale wrapped to ratio", v, 32'h03CF);
    rd_reg(2'd0, v);  check("R2 count stepped once", v, 32'hFFFE);
    rd_reg(2'd3, v);  check("R9 unused address", v, 32'h0);

    run_interval(2, 3);
    run_interval(0, 4);
    run_interval(3, 0);

    // R5: frozen while halted
    rd_reg(2'd0, v);
    rd_reg(2'd2, v2);
    repeat (30) @(negedge clk);
    begin
      logic [15:0] w;
      rd_reg(2'd0, w);  check("R5 count frozen", w, 32'(v));
      rd_reg(2'd2, w);  check("R5 prescale frozen", w, 32'(v2));
    end

    // R8: direct count write while running with ratio 0
    wr_reg(2'd1, 16'h0100, e);
    wr_reg(2'd2, 16'h0030, e);
    wr_reg(2'd2, 16'h0000, e);
    repeat (5) @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 16'h0002;
    e = cyc + 1;
    exp_q.push_back(e + 3);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    rd_reg(2'd0, v);  check("R8 written count, no decrement", v, 32'h0002);
    @(negedge clk);
    rd_reg(2'd0, v);  check("R8 decrement resumes", v, 32'h0001);
    wait (exp_q.size() == 0);
    wr_reg(2'd2, 16'h0010, e);

    // R7: spare bits stored, prescale field and top bits not writable
    wr_reg(2'd2, 16'hFFD5, e);
    rd_reg(2'd2, v);  check("R7 control layout", v, 32'h0C15);
    rd_reg(2'd1, v);  check("R9 period readback", v, 32'h0100);

    repeat (5) @(negedge clk);
    check("R3 no pending pulses", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule